// File: doc/BRIEF.md
# Cable-Plug Identity Responder

This block answers identity queries that a power-delivery source or downstream port sends to a cable plug. Decoded data objects of an incoming data message arrive one per cycle. The object flagged as the first one is classified as a vendor-defined message header. All later objects of the message are ignored. The block only ever responds and never initiates. It answers a well-formed identity request by streaming back a fixed sequence of 32-bit objects over a valid/ready interface. The reply fields come from four identity registers, which a host write port loads.

The reply is one of two kinds. The first is a positive acknowledgement: a header, an identity header, a certification object, a product object and, for cable product types only, a cable object. The second is a one-object refusal that echoes the request header. Alongside the stream the block presents the number of objects in the reply, so that an upstream message-header generator can fill in its object-count field. A new request that arrives while a reply is still streaming cancels that reply and starts the new one.

Top module: `vdm_id_responder`

## Requirements
- R1: After reset, `tx_valid` is 0 and all four identity registers read as zero in a reply.
- R2: A first object with bit 15 equal to 0 (unstructured message) produces no reply.
- R3: A first object whose bits [7:6] are not 00 (i.e. not an initiator request) produces no reply.
- R4: A request with command bits [4:0] = 1 and bits [31:16] = 0xFF00 is acknowledged. The first reply object is exactly 0xFF008041: SVID 0xFF00, bit 15 = 1, version bits [14:13] = 0, object position 0, bits [7:6] = 01, command 1.
- R5: An acknowledged reply continues in this order: identity header (register 0), certification object (register 1), product object (register 2), cable object (register 3). The cable object is sent, and `tx_count` is 5, only when identity header bits [29:27] are 011 or 100. Otherwise `tx_count` is 4.
- R6: In the reply, identity header bits [25:16] and certification bits [31:20] are zero, whatever the register holds.
- R7: A request with any command other than 1, or with command 1 and an SVID other than 0xFF00, gets a single object: the request header with bits [7:6] = 10, bits [12:11] and bit 5 cleared, and `tx_count` = 1.
- R8: Request bits [12:11] and bit 5 do not affect the decision; an identity request with them set is still acknowledged.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data`, `tx_last` and `tx_valid` hold their values.
- R10: A new accepted request during a reply aborts it; the next object presented is the first object of the new reply.
- R11: `tx_last` is 1 on the final object of a reply and on no other object.
- R12: Objects presented with `rx_first` = 0 never start a reply.
- R13: A host write with `cfg_we` = 1 stores `cfg_wdata` into register `cfg_addr` (0 identity, 1 certification, 2 product, 3 cable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Incoming data object valid |
| rx_first | input | 1 | Object is the first of its message |
| rx_data | input | 32 | Incoming data object |
| cfg_we | input | 1 | Host register write strobe |
| cfg_addr | input | 2 | Host register select |
| cfg_wdata | input | 32 | Host write data |
| tx_valid | output | 1 | Reply object valid |
| tx_ready | input | 1 | Downstream accepts reply object |
| tx_data | output | 32 | Reply object |
| tx_last | output | 1 | Final object of reply |
| tx_count | output | 3 | Number of objects in current reply |

## Verification
The hardest case to reach is the abort of a reply in mid-stream. The bench brings it about by holding `tx_ready` low after an identity request, so that the five-object acknowledgement stalls on its header. While the reply is stalled, the bench injects an unsupported command. It then releases the stream and expects only the single refusal object, marked last. The same stall window also shows that the stalled object holds steady under back-pressure.

// File: rtl/vdm_pkg.sv
// Package: shared constants and types for the identity responder.
// Assumes 32-bit data objects and field positions fixed by the header layout.
package vdm_pkg;
    localparam int OBJ_W = 32;
    localparam int CNT_W = 3;
    localparam logic [15:0] PD_SID = 16'hFF00;
    localparam logic [4:0] CMD_IDENT = 5'd1;

    typedef enum logic [1:0] {
        CT_INIT = 2'b00,
        CT_ACK  = 2'b01,
        CT_NAK  = 2'b10,
        CT_BUSY = 2'b11
    } cmd_type_e;

    typedef enum logic [0:0] {
        RPL_ACK = 1'b0,
        RPL_NAK = 1'b1
    } reply_kind_e;

    localparam logic [2:0] PT_PASSIVE = 3'b011;
    localparam logic [2:0] PT_ACTIVE  = 3'b100;
endpackage

// File: rtl/vdm_cfg_regs.sv
// Module: identity register block loaded by a host write port.
// Holds N_REGS words; all read continuously. Reset clears all words.
module vdm_cfg_regs #(
    parameter int OBJ_W  = 32,
    parameter int N_REGS = 4,
    localparam int ADDR_W = $clog2(N_REGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [OBJ_W-1:0]     wdata,
    output logic [OBJ_W-1:0]     regs [N_REGS]
);
    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        // Store host data into the selected word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && addr == ADDR_W'(g))
                regs[g] <= wdata;
        end

        a_r13_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (we && addr == ADDR_W'(g)) |=> regs[g] == $past(wdata));
    end
endmodule

// File: rtl/vdm_hdr_decode.sv
// Module: classifies a received header object.
// Purely combinational; reserved request bits are never examined.
module vdm_hdr_decode
    import vdm_pkg::*;
(
    input  logic [OBJ_W-1:0] hdr,
    output logic             respond,
    output logic             is_ack,
    output logic [OBJ_W-1:0] nak_hdr
);
    logic       structured;
    logic [1:0] ctype;
    logic [4:0] cmd;
    logic [15:0] svid;

    // Split the header into the fields that drive the decision.
    always_comb begin
        structured = hdr[15];
        ctype      = hdr[7:6];
        cmd        = hdr[4:0];
        svid       = hdr[31:16];
    end

    // Respond only to structured initiator requests; ack only identity to the SID.
    always_comb begin
        respond = structured && (ctype == CT_INIT);
        is_ack  = (cmd == CMD_IDENT) && (svid == PD_SID);
    end

    // Refusal echoes the header with cleared reserved bits and NAK type.
    always_comb begin
        nak_hdr        = hdr;
        nak_hdr[12:11] = 2'b00;
        nak_hdr[5]     = 1'b0;
        nak_hdr[7:6]   = CT_NAK;
    end
endmodule

// File: rtl/vdm_reply_seq.sv
// Module: reply sequencer and object multiplexer.
// Assumes accept is a single-cycle qualifier; a new accept overrides any reply in flight.
module vdm_reply_seq
    import vdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             is_ack,
    input  logic [OBJ_W-1:0] nak_hdr,
    input  logic [OBJ_W-1:0] id_reg,
    input  logic [OBJ_W-1:0] cert_reg,
    input  logic [OBJ_W-1:0] prod_reg,
    input  logic [OBJ_W-1:0] cable_reg,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [OBJ_W-1:0] tx_data,
    output logic             tx_last,
    output logic [CNT_W-1:0] tx_count
);
    localparam logic [OBJ_W-1:0] ACK_HDR = {PD_SID, 1'b1, 2'b00, 2'b00, 3'b000, CT_ACK, 1'b0, CMD_IDENT};

    logic             active_q;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    reply_kind_e      kind_q;
    logic [OBJ_W-1:0] nak_q;
    logic             is_cable;
    logic             at_end;

    // Cable product types carry the extra cable object.
    always_comb begin
        is_cable = (id_reg[29:27] == PT_PASSIVE) || (id_reg[29:27] == PT_ACTIVE);
        at_end   = (idx_q == cnt_q - CNT_W'(1));
    end

    // Load a new reply on accept, otherwise step on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            cnt_q    <= '0;
            kind_q   <= RPL_ACK;
            nak_q    <= '0;
        end else if (accept) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            kind_q   <= is_ack ? RPL_ACK : RPL_NAK;
            nak_q    <= nak_hdr;
            cnt_q    <= !is_ack ? CNT_W'(1) : (is_cable ? CNT_W'(5) : CNT_W'(4));
        end else if (active_q && tx_ready) begin
            if (at_end)
                active_q <= 1'b0;
            else
                idx_q <= idx_q + CNT_W'(1);
        end
    end

    // Pick the current object, forcing reserved fields to zero.
    always_comb begin
        tx_data = '0;
        unique case (idx_q)
            3'd0: tx_data = (kind_q == RPL_ACK) ? ACK_HDR : nak_q;
            3'd1: tx_data = {id_reg[31:26], 10'd0, id_reg[15:0]};
            3'd2: tx_data = {12'd0, cert_reg[19:0]};
            3'd3: tx_data = prod_reg;
            3'd4: tx_data = cable_reg;
            default: tx_data = '0;
        endcase
    end

    // Drive the stream flags.
    always_comb begin
        tx_valid = active_q;
        tx_last  = active_q && at_end;
        tx_count = cnt_q;
    end

    a_r5_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_count == 3'd1 || tx_count == 3'd4 || tx_count == 3'd5));
    a_r6_id_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && idx_q == 3'd1) |-> tx_data[25:16] == 10'd0);
    a_r10_restart_at_head: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tx_valid && idx_q == '0));
    a_r11_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last && tx_ready && !accept) |=> !tx_valid);
endmodule

// File: rtl/vdm_id_responder.sv
// Module: top of the cable-plug identity responder.
// Assumes rx_first marks the header object of each incoming data message.
module vdm_id_responder
    import vdm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_first,
    input  logic [31:0] rx_data,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [31:0] tx_data,
    output logic        tx_last,
    output logic [2:0]  tx_count
);
    logic [OBJ_W-1:0] regs [4];
    logic             respond;
    logic             is_ack;
    logic [OBJ_W-1:0] nak_hdr;
    logic             accept;

    vdm_cfg_regs #(.OBJ_W(OBJ_W), .N_REGS(4)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .regs(regs)
    );

    vdm_hdr_decode u_dec (
        .hdr(rx_data), .respond(respond), .is_ack(is_ack), .nak_hdr(nak_hdr)
    );

    // Only the first object of a message may start a reply.
    always_comb accept = rx_valid && rx_first && respond;

    vdm_reply_seq u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .is_ack(is_ack),
        .nak_hdr(nak_hdr), .id_reg(regs[0]), .cert_reg(regs[1]),
        .prod_reg(regs[2]), .cable_reg(regs[3]), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_count(tx_count)
    );

    a_r2_unstructured_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_first && !rx_data[15] && !tx_valid) |=> !tx_valid);
    a_r3_non_initiator_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_first && rx_data[7:6] != 2'b00 && !tx_valid) |=> !tx_valid);
    a_r12_later_objects_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_first && !tx_valid) |=> !tx_valid);
    a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !(rx_valid && rx_first) && !cfg_we)
        |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
endmodule

// File: tb/sim_vdm_id_responder.sv
module sim_vdm_id_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_first = 1'b0;
    logic [31:0] rx_data = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [31:0] tx_data;
    logic        tx_last;
    logic [2:0]  tx_count;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] got [8];
    logic        got_last [8];
    int          n_got;

    always #5 clk = ~clk;

    vdm_id_responder u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_first(rx_first),
        .rx_data(rx_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .tx_count(tx_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [31:0] h, input logic first);
        @(negedge clk);
        rx_valid = 1'b1; rx_first = first; rx_data = h;
        @(negedge clk);
        rx_valid = 1'b0; rx_first = 1'b0;
    endtask

    task automatic collect();
        n_got = 0;
        for (int i = 0; i < 10; i++) begin
            if (tx_valid && tx_ready && n_got < 8) begin
                got[n_got] = tx_data;
                got_last[n_got] = tx_last;
                n_got++;
                if (tx_last) begin
                    @(negedge clk);
                    break;
                end
            end
            @(negedge clk);
        end
    endtask

    task automatic expect_quiet(input string req);
        logic seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (tx_valid) seen = 1'b1;
            @(negedge clk);
        end
        check(req, {31'd0, seen}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 tx_valid after reset", {31'd0, tx_valid}, 32'd0);
        send(32'hFF00_8001, 1'b1);
        check("R1 count", {29'd0, tx_count}, 32'd4);
        collect();
        check("R1 id header zero", got[1], 32'd0);
        check("R1 cert zero", got[2], 32'd0);
    endtask

    task automatic t_cable_ack();
        wr(2'd0, 32'hDBFF_1234);
        wr(2'd1, 32'hFFF1_2345);
        wr(2'd2, 32'hABCD_0102);
        wr(2'd3, 32'h1122_3344);
        send(32'hFF00_8001, 1'b1);
        check("R5 count cable", {29'd0, tx_count}, 32'd5);
        collect();
        check("R5 objects", n_got, 5);
        check("R4 header", got[0], 32'hFF00_8041);
        check("R6 R13 id header", got[1], 32'hD800_1234);
        check("R6 R13 cert", got[2], 32'h0001_2345);
        check("R5 product", got[3], 32'hABCD_0102);
        check("R5 cable", got[4], 32'h1122_3344);
        check("R11 last only at end", {got_last[0], got_last[1], got_last[2], got_last[3], got_last[4]}, 32'b00001);
    endtask

    task automatic t_noncable_ack();
        wr(2'd0, 32'h5000_5678);
        send(32'hFF00_8001, 1'b1);
        check("R5 count non-cable", {29'd0, tx_count}, 32'd4);
        collect();
        check("R5 objects non-cable", n_got, 4);
        check("R5 id header", got[1], 32'h5000_5678);
        check("R11 last on 4th", {28'd0, got_last[0], got_last[1], got_last[2], got_last[3]}, 32'b0001);
        wr(2'd0, 32'hDBFF_1234);
    endtask

    task automatic t_reserved_ignored();
        send(32'hFF00_9821, 1'b1);
        collect();
        check("R8 header", got[0], 32'hFF00_8041);
        check("R8 objects", n_got, 5);
    endtask

    task automatic t_nak();
        send(32'hFF01_9821, 1'b1);
        check("R7 count", {29'd0, tx_count}, 32'd1);
        collect();
        check("R7 wrong svid nak", got[0], 32'hFF01_8081);
        check("R7 single last", {31'd0, got_last[0]}, 32'd1);
        send(32'hFF00_8003, 1'b1);
        collect();
        check("R7 other cmd nak", got[0], 32'hFF00_8083);
        check("R7 objects", n_got, 1);
    endtask

    task automatic t_ignored();
        send(32'hFF00_0001, 1'b1);
        expect_quiet("R2 unstructured ignored");
        send(32'hFF00_8041, 1'b1);
        expect_quiet("R3 ack type ignored");
        send(32'hFF00_80C1, 1'b1);
        expect_quiet("R3 busy type ignored");
        send(32'hFF00_8001, 1'b0);
        expect_quiet("R12 non-first ignored");
    endtask

    task automatic t_stall_abort();
        logic [31:0] first_seen;
        tx_ready = 1'b0;
        send(32'hFF00_8001, 1'b1);
        first_seen = tx_data;
        @(negedge clk);
        @(negedge clk);
        check("R9 data held", tx_data, first_seen);
        check("R9 valid held", {31'd0, tx_valid}, 32'd1);
        send(32'hFF00_8004, 1'b1);
        check("R10 new head", tx_data, 32'hFF00_8084);
        tx_ready = 1'b1;
        collect();
        check("R10 objects after abort", n_got, 1);
        check("R10 last", {31'd0, got_last[0]}, 32'd1);
        expect_quiet("R10 nothing after");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cable_ack();
        t_noncable_ack();
        t_reserved_ignored();
        t_nak();
        t_ignored();
        t_stall_abort();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule